// File: doc/BRIEF.md
# Interrupt CPU Interface Arbiter

This block is the per-processor front end of an interrupt controller. A distributor supplies it with pending, enable and priority vectors. From those it picks the one interrupt that should go to the processor next and screens it against a programmable priority mask and against the priority of the interrupt already in service. It drives a single level IRQ line towards the core.

Software talks to the block through a small word-addressed register window. Reading the acknowledge word takes the current winner into service. The block emits a one-cycle pulse with the interrupt ID, so the distributor can mark that interrupt active. It also raises the running priority to the level of that interrupt.

Writing an ID to the completion word ends service of the innermost active interrupt. The block emits a one-cycle pulse with that ID and returns the running priority to the level below. Nested service is tracked on an internal stack. A start-up routine can drain leftovers by alternately reading the acknowledge word and writing its value back until the reserved ID 1023 appears.

Top module: `irq_cpu_front`

## Requirements
- R1: After a synchronous active-low reset, `irq_out`, `ack_pulse` and `eoi_pulse` are low, `run_prio` is 0xFF, the control word reads 0 and the mask word reads 0x00.
- R2: A write to the mask word (offset 0x04) keeps only the upper PRIO_BITS bits of data bits 7:0; the lower bits read as zero. With the default PRIO_BITS=4, writing 0xFF reads back 0xF0, and writing 0xA8 reads back 0xA0.
- R3: An interrupt qualifies when its pending bit and its enable bit are both set and its priority is numerically below the stored mask. Before the comparison, the interrupt's 8-bit priority is cut to the same upper PRIO_BITS bits. A mask of 0x00 therefore blocks every level.
- R4: Among the qualifying interrupts, the winner is the one with the lowest priority value; on equal values the lowest ID wins. A read of the highest-pending word (offset 0x18) returns the winner's ID in bits 9:0, or 1023 when nothing qualifies, and changes no state.
- R5: `irq_out` is high exactly when control bit 0 is set, a winner exists and its priority is numerically below `run_prio`. It is registered and follows its inputs one clock edge later.
- R6: A read of the acknowledge word (offset 0x0C) returns the winner's ID in bits 9:0 when a winner exists whose priority is below `run_prio`; this does not depend on control bit 0. The same read raises `ack_pulse` for one cycle with that ID on `ack_id` and sets `run_prio` to the winner's priority.
- R7: When no winner beats `run_prio`, an acknowledge read returns 1023, gives no `ack_pulse` and leaves `run_prio` unchanged.
- R8: A write to the completion word (offset 0x10) whose data bits 9:0 equal the most recently acknowledged interrupt still in service raises `eoi_pulse` for one cycle with that ID on `eoi_id`. It also restores `run_prio` to its value before that acknowledge. A write of any other ID gives no pulse and leaves `run_prio` unchanged.
- R9: Acknowledges nest: a higher-priority interrupt can be acknowledged while another is in service. Completing the inner interrupt returns `run_prio` to the outer interrupt's level, and completing the outer one returns it to 0xFF.
- R10: The control word (offset 0x00) stores and reads back bit 0. The binary-point word (offset 0x08) stores and reads back data bits 2:0 and has no other effect. The identification word (offset 0xFC) reads the IDENT_VAL parameter (default 0x0002_0A10). All register reads deliver their data on `bus_rdata` after the clock edge that takes the access.
- R11: Repeatedly reading the acknowledge word and writing the returned ID back to the completion word takes the interrupts in priority order. When the distributor clears each pending bit once it has been acknowledged, the loop ends with a read of 1023 and `run_prio` back at 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pend_vec | input | NUM_IRQ | Pending bit per interrupt from the distributor |
| en_vec | input | NUM_IRQ | Enable bit per interrupt from the distributor |
| prio_vec | input | 8*NUM_IRQ | 8-bit priority per interrupt; interrupt i in bits 8i+7:8i |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_out | output | 1 | Interrupt request to the processor |
| ack_pulse | output | 1 | One-cycle pulse: interrupt taken into service |
| ack_id | output | 10 | ID that goes with `ack_pulse` |
| eoi_pulse | output | 1 | One-cycle pulse: service completed |
| eoi_id | output | 10 | ID that goes with `eoi_pulse` |
| run_prio | output | 8 | Current running priority, 0xFF when idle |

## Verification
A register read presents its data after the single edge that takes the access. The acknowledge and completion pulses and the new `run_prio` also appear after that same edge. The bench starts every access on a falling edge and samples all of these on the next falling edge, exactly one rising edge later. `irq_out` needs one more edge after any change of inputs, mask or running priority, so the bench waits at least two full cycles before it compares the IRQ line. The vector table covers the qualifying and winner rules, and the directed sequences cover nesting, spurious acknowledges, ignored completions and the drain loop.

// File: rtl/irqf_pkg.sv
// Shared constants and types of the interrupt CPU front end.
// Assumes 8-bit priorities and 10-bit interrupt IDs throughout.
package irqf_pkg;
    localparam int PRIO_W = 8;
    localparam int ID_W   = 10;
    localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_MASK  = 8'h04;
    localparam logic [7:0] OFS_BPT   = 8'h08;
    localparam logic [7:0] OFS_ACK   = 8'h0C;
    localparam logic [7:0] OFS_EOI   = 8'h10;
    localparam logic [7:0] OFS_RUN   = 8'h14;
    localparam logic [7:0] OFS_HPEND = 8'h18;
    localparam logic [7:0] OFS_IDENT = 8'hFC;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [PRIO_W-1:0] prio;
    } act_entry_t;
endpackage

// File: rtl/irqf_pick.sv
// Winner selection: qualifies each interrupt against pending, enable and
// the priority mask, then picks the lowest priority value, lowest ID on ties.
// Assumes NUM_IRQ <= 1023 so that no real ID collides with the spurious ID.
module irqf_pick
    import irqf_pkg::*;
#(
    parameter int NUM_IRQ   = 64,
    parameter int PRIO_BITS = 4
) (
    input  logic [NUM_IRQ-1:0]        pend_vec,
    input  logic [NUM_IRQ-1:0]        en_vec,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_vec,
    input  logic [PRIO_W-1:0]         mask,
    output logic                      win_valid,
    output logic [ID_W-1:0]           win_id,
    output logic [PRIO_W-1:0]         win_prio
);
    localparam logic [PRIO_W-1:0] IMPL =
        PRIO_W'(((1 << PRIO_BITS) - 1) << (PRIO_W - PRIO_BITS));

    logic [PRIO_W-1:0] prio_cut [NUM_IRQ];
    logic [NUM_IRQ-1:0] qual;

    // Per-line truncation and qualification against the mask.
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
        assign prio_cut[g] = prio_vec[g*PRIO_W +: PRIO_W] & IMPL;
        assign qual[g]     = pend_vec[g] & en_vec[g] & (prio_cut[g] < mask);
    end

    // Scan in ID order; strict compare keeps the lowest ID on equal levels.
    always_comb begin
        win_valid = 1'b0;
        win_id    = '0;
        win_prio  = '1;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (qual[i] && (!win_valid || prio_cut[i] < win_prio)) begin
                win_valid = 1'b1;
                win_id    = ID_W'(i);
                win_prio  = prio_cut[i];
            end
        end
    end
endmodule

// File: rtl/irqf_stack.sv
// In-service stack: one entry per acknowledged interrupt still in service.
// Each push must carry a strictly lower priority value than the top, so at
// most 2**PRIO_BITS entries can ever be live; pushes beyond that are dropped.
module irqf_stack
    import irqf_pkg::*;
#(
    parameter int PRIO_BITS = 4,
    localparam int DEPTH = 1 << PRIO_BITS,
    localparam int PTR_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  act_entry_t        push_entry,
    input  logic              pop,
    output logic              top_valid,
    output act_entry_t        top_entry,
    output logic [PTR_W-1:0]  depth
);
    act_entry_t         mem [DEPTH];
    logic [PTR_W-1:0]   depth_q;
    logic [IDX_W-1:0]   top_idx;

    assign top_idx   = IDX_W'(depth_q - PTR_W'(1));
    assign top_valid = (depth_q != '0);
    assign top_entry = mem[top_idx];
    assign depth     = depth_q;

    // Depth counter: push has precedence, pop only when not empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth_q <= '0;
        end else if (push && depth_q < PTR_W'(DEPTH)) begin
            depth_q <= depth_q + PTR_W'(1);
        end else if (pop && depth_q != '0) begin
            depth_q <= depth_q - PTR_W'(1);
        end
    end

    // Entry storage, written at the slot above the current top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push && depth_q < PTR_W'(DEPTH)) begin
            mem[IDX_W'(depth_q)] <= push_entry;
        end
    end
endmodule

// File: rtl/irqf_regs.sv
// Register window: decodes accesses, holds control, mask and binary point,
// produces the registered read data and the acknowledge/completion pulses.
// Assumes at most one access per cycle; read data is valid after the edge.
module irqf_regs
    import irqf_pkg::*;
#(
    parameter int          PRIO_BITS = 4,
    parameter logic [31:0] IDENT_VAL = 32'h0002_0A10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              win_valid,
    input  logic [ID_W-1:0]   win_id,
    input  logic [PRIO_W-1:0] win_prio,
    input  logic [PRIO_W-1:0] run_prio,
    input  logic              top_valid,
    input  logic [ID_W-1:0]   top_id,
    output logic              ctrl_en,
    output logic [PRIO_W-1:0] mask,
    output logic              push,
    output logic              pop,
    output logic              ack_pulse,
    output logic [ID_W-1:0]   ack_id,
    output logic              eoi_pulse,
    output logic [ID_W-1:0]   eoi_id
);
    localparam logic [PRIO_W-1:0] IMPL =
        PRIO_W'(((1 << PRIO_BITS) - 1) << (PRIO_W - PRIO_BITS));

    logic        ctrl_q;
    logic [7:0]  mask_q;
    logic [2:0]  bpt_q;
    logic [31:0] rdata_q;
    logic [31:0] rd_mux;
    logic        rd_hit, wr_hit, ack_ok;
    logic        unused_wdata;

    assign unused_wdata = ^bus_wdata[31:10];

    assign rd_hit  = bus_sel && !bus_wr;
    assign wr_hit  = bus_sel && bus_wr;
    assign ack_ok  = win_valid && (win_prio < run_prio);
    assign push    = rd_hit && bus_addr == OFS_ACK && ack_ok;
    assign pop     = wr_hit && bus_addr == OFS_EOI && top_valid &&
                     bus_wdata[ID_W-1:0] == top_id;

    assign ctrl_en   = ctrl_q;
    assign mask      = mask_q;
    assign bus_rdata = rdata_q;

    // Read multiplexer over the register words.
    always_comb begin
        case (bus_addr)
            OFS_CTRL:  rd_mux = {31'b0, ctrl_q};
            OFS_MASK:  rd_mux = {24'b0, mask_q};
            OFS_BPT:   rd_mux = {29'b0, bpt_q};
            OFS_ACK:   rd_mux = {22'b0, ack_ok ? win_id : SPURIOUS_ID};
            OFS_RUN:   rd_mux = {24'b0, run_prio};
            OFS_HPEND: rd_mux = {22'b0, win_valid ? win_id : SPURIOUS_ID};
            OFS_IDENT: rd_mux = IDENT_VAL;
            default:   rd_mux = 32'b0;
        endcase
    end

    // Writable configuration words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= 1'b0;
            mask_q <= '0;
            bpt_q  <= '0;
        end else if (wr_hit) begin
            if (bus_addr == OFS_CTRL) ctrl_q <= bus_wdata[0];
            if (bus_addr == OFS_MASK) mask_q <= bus_wdata[7:0] & IMPL;
            if (bus_addr == OFS_BPT)  bpt_q  <= bus_wdata[2:0];
        end
    end

    // Registered read data, updated on every read access.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_hit) rdata_q <= rd_mux;
    end

    // One-cycle acknowledge and completion pulses with their IDs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_pulse <= 1'b0;
            ack_id    <= '0;
            eoi_pulse <= 1'b0;
            eoi_id    <= '0;
        end else begin
            ack_pulse <= push;
            eoi_pulse <= pop;
            if (push) ack_id <= win_id;
            if (pop)  eoi_id <= top_id;
        end
    end
endmodule

// File: rtl/irq_cpu_front.sv
// Top of the interrupt CPU front end: winner selection, register window,
// in-service stack and the registered IRQ line.
// Assumes distributor vectors are synchronous to clk.
module irq_cpu_front
    import irqf_pkg::*;
#(
    parameter int          NUM_IRQ   = 64,
    parameter int          PRIO_BITS = 4,
    parameter logic [31:0] IDENT_VAL = 32'h0002_0A10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_IRQ-1:0]     pend_vec,
    input  logic [NUM_IRQ-1:0]     en_vec,
    input  logic [NUM_IRQ*8-1:0]   prio_vec,
    input  logic                   bus_sel,
    input  logic                   bus_wr,
    input  logic [7:0]             bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    output logic                   irq_out,
    output logic                   ack_pulse,
    output logic [9:0]             ack_id,
    output logic                   eoi_pulse,
    output logic [9:0]             eoi_id,
    output logic [7:0]             run_prio
);
    localparam int DEPTH = 1 << PRIO_BITS;
    localparam int PTR_W = $clog2(DEPTH + 1);

    logic              win_valid;
    logic [ID_W-1:0]   win_id;
    logic [PRIO_W-1:0] win_prio;
    logic [PRIO_W-1:0] mask;
    logic              ctrl_en, push, pop, top_valid;
    act_entry_t        top_entry;
    act_entry_t        push_entry;
    logic [PTR_W-1:0]  depth;
    logic              irq_q;

    irqf_pick #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS)) u_pick (
        .pend_vec (pend_vec),
        .en_vec   (en_vec),
        .prio_vec (prio_vec),
        .mask     (mask),
        .win_valid(win_valid),
        .win_id   (win_id),
        .win_prio (win_prio)
    );

    assign push_entry = '{id: win_id, prio: win_prio};

    irqf_stack #(.PRIO_BITS(PRIO_BITS)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_entry(push_entry),
        .pop       (pop),
        .top_valid (top_valid),
        .top_entry (top_entry),
        .depth     (depth)
    );

    assign run_prio = top_valid ? top_entry.prio : 8'hFF;

    irqf_regs #(.PRIO_BITS(PRIO_BITS), .IDENT_VAL(IDENT_VAL)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .win_valid(win_valid),
        .win_id   (win_id),
        .win_prio (win_prio),
        .run_prio (run_prio),
        .top_valid(top_valid),
        .top_id   (top_entry.id),
        .ctrl_en  (ctrl_en),
        .mask     (mask),
        .push     (push),
        .pop      (pop),
        .ack_pulse(ack_pulse),
        .ack_id   (ack_id),
        .eoi_pulse(eoi_pulse),
        .eoi_id   (eoi_id)
    );

    // IRQ line: enabled, a winner exists and it beats the running level.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= ctrl_en && win_valid && (win_prio < run_prio);
    end

    assign irq_out = irq_q;
endmodule

// File: rtl/irqf_checker.sv
// Temporal checks on the front end's ports and stack depth.
// Attached to every instance of irq_cpu_front by the bind below.
module irqf_checker #(
    parameter int PRIO_BITS = 4,
    localparam int DEPTH = 1 << PRIO_BITS,
    localparam int PTR_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_out,
    input logic             ack_pulse,
    input logic [9:0]       ack_id,
    input logic             eoi_pulse,
    input logic [7:0]       run_prio,
    input logic             ctrl_en,
    input logic [PTR_W-1:0] depth
);
    assert_irq_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> $past(ctrl_en));

    assert_ack_not_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_pulse |-> ack_id != 10'd1023);

    assert_ack_raises_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_pulse |-> run_prio < $past(run_prio));

    assert_eoi_lowers_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_pulse |-> run_prio > $past(run_prio));

    assert_single_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_pulse && eoi_pulse));

    assert_depth_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        int'(depth) <= DEPTH);
endmodule

bind irq_cpu_front irqf_checker #(.PRIO_BITS(PRIO_BITS)) u_irqf_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_out  (irq_out),
    .ack_pulse(ack_pulse),
    .ack_id   (ack_id),
    .eoi_pulse(eoi_pulse),
    .run_prio (run_prio),
    .ctrl_en  (ctrl_en),
    .depth    (depth)
);

// File: tb/test_irq_cpu_front.sv
// Self-checking bench: a vector table for the winner and mask rules, then
// directed tests for reset, registers, nesting and the drain loop.
module test_irq_cpu_front;
    localparam int N = 64;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   pend = '0;
    logic [N-1:0]   en = '0;
    logic [N*8-1:0] prio = '0;
    logic           sel = 1'b0, wr = 1'b0;
    logic [7:0]     addr = '0;
    logic [31:0]    wdata = '0;
    logic [31:0]    rdata;
    logic           irq_out, ack_pulse, eoi_pulse;
    logic [9:0]     ack_id, eoi_id;
    logic [7:0]     run_prio;

    logic           s_ack, s_eoi;
    logic [9:0]     s_ack_id, s_eoi_id;
    int             n_chk = 0, n_bad = 0;
    logic [31:0]    rd;

    always #2 clk = ~clk;

    irq_cpu_front i_irq_cpu_front (
        .clk(clk), .rst_n(rst_n), .pend_vec(pend), .en_vec(en), .prio_vec(prio),
        .bus_sel(sel), .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata), .irq_out(irq_out), .ack_pulse(ack_pulse),
        .ack_id(ack_id), .eoi_pulse(eoi_pulse), .eoi_id(eoi_id), .run_prio(run_prio)
    );

    typedef struct packed {
        logic [63:0] pend;
        logic [63:0] en;
        logic [7:0]  mask;
        logic [5:0]  oa_id;
        logic [7:0]  oa_pr;
        logic [5:0]  ob_id;
        logic [7:0]  ob_pr;
        logic [9:0]  exp_id;
        logic        exp_irq;
    } vec_t;

    localparam vec_t VECS [11] = '{
        '{64'h0, '1, 8'hFF, 6'd63, 8'hA0, 6'd63, 8'hA0, 10'd1023, 1'b0},
        '{64'h20, '1, 8'hFF, 6'd63, 8'hA0, 6'd63, 8'hA0, 10'd5, 1'b1},
        '{64'h20, 64'h0, 8'hFF, 6'd63, 8'hA0, 6'd63, 8'hA0, 10'd1023, 1'b0},
        '{64'h0000_0100_0000_0008, '1, 8'hFF, 6'd40, 8'h20, 6'd63, 8'hA0, 10'd40, 1'b1},
        '{64'h0000_0100_0000_0008, '1, 8'hFF, 6'd63, 8'hA0, 6'd63, 8'hA0, 10'd3, 1'b1},
        '{64'h80, '1, 8'hA0, 6'd63, 8'hA0, 6'd63, 8'hA0, 10'd1023, 1'b0},
        '{64'h80, '1, 8'hB0, 6'd63, 8'hA0, 6'd63, 8'hA0, 10'd7, 1'b1},
        '{64'h80, '1, 8'hA8, 6'd7, 8'hA5, 6'd63, 8'hA0, 10'd1023, 1'b0},
        '{64'h0000_0100_0000_0008, 64'h0000_0100_0000_0000, 8'hFF, 6'd3, 8'h00, 6'd63, 8'hA0, 10'd40, 1'b1},
        '{'1, '1, 8'hFF, 6'd63, 8'h10, 6'd62, 8'h10, 10'd62, 1'b1},
        '{64'h2, '1, 8'h00, 6'd1, 8'h00, 6'd63, 8'hA0, 10'd1023, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // One register access; results are sampled one rising edge later.
    task automatic bus(input logic w, input logic [7:0] a, input logic [31:0] d,
                       output logic [31:0] r);
        @(negedge clk);
        sel = 1'b1; wr = w; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
        r = rdata; s_ack = ack_pulse; s_ack_id = ack_id;
        s_eoi = eoi_pulse; s_eoi_id = eoi_id;
    endtask

    task automatic set_prio(input int id, input logic [7:0] p);
        prio[id*8 +: 8] = p;
    endtask

    task automatic wait_cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] dummy;
        int iters;
        logic [9:0] order [3];
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 irq_out", {31'b0, irq_out}, 0);
        check("R1 run_prio", {24'b0, run_prio}, 32'hFF);
        check("R1 ack_pulse", {31'b0, ack_pulse}, 0);
        check("R1 eoi_pulse", {31'b0, eoi_pulse}, 0);
        bus(0, 8'h00, 0, rd); check("R1 control", rd, 0);
        bus(0, 8'h04, 0, rd); check("R1 mask", rd, 0);

        // R2: mask keeps only implemented bits
        bus(1, 8'h04, 32'hFF, dummy); bus(0, 8'h04, 0, rd); check("R2 mask 0xFF", rd, 32'hF0);
        bus(1, 8'h04, 32'hA8, dummy); bus(0, 8'h04, 0, rd); check("R2 mask 0xA8", rd, 32'hA0);

        // R10: control, binary point and identification words
        bus(1, 8'h08, 32'h7, dummy); bus(0, 8'h08, 0, rd); check("R10 bpt 7", rd, 32'h7);
        bus(1, 8'h08, 32'hFA, dummy); bus(0, 8'h08, 0, rd); check("R10 bpt low bits", rd, 32'h2);
        bus(0, 8'hFC, 0, rd); check("R10 ident", rd, 32'h0002_0A10);
        bus(1, 8'h00, 32'h1, dummy); bus(0, 8'h00, 0, rd); check("R10 control", rd, 32'h1);

        // R5: IRQ gated by control bit 0
        for (int i = 0; i < N; i++) set_prio(i, 8'hA0);
        en = '1; pend = 64'h20;
        bus(1, 8'h04, 32'hFF, dummy);
        bus(1, 8'h00, 32'h0, dummy);
        wait_cyc(3); check("R5 irq low while disabled", {31'b0, irq_out}, 0);
        bus(1, 8'h00, 32'h1, dummy);
        wait_cyc(3); check("R5 irq high once enabled", {31'b0, irq_out}, 1);

        // R3/R4: vector table
        for (int v = 0; v < 11; v++) begin
            for (int i = 0; i < N; i++) set_prio(i, 8'hA0);
            set_prio(int'(VECS[v].oa_id), VECS[v].oa_pr);
            set_prio(int'(VECS[v].ob_id), VECS[v].ob_pr);
            pend = VECS[v].pend; en = VECS[v].en;
            bus(1, 8'h04, {24'b0, VECS[v].mask}, dummy);
            wait_cyc(3);
            bus(0, 8'h18, 0, rd);
            check($sformatf("R4 R3 vector %0d highest pending", v), rd, {22'b0, VECS[v].exp_id});
            check($sformatf("R5 R3 vector %0d irq", v), {31'b0, irq_out}, {31'b0, VECS[v].exp_irq});
        end
        check("R4 highest pending read has no pulse", {31'b0, s_ack}, 0);
        check("R4 highest pending leaves run_prio", {24'b0, run_prio}, 32'hFF);

        // R6/R7/R8/R9: nested service
        for (int i = 0; i < N; i++) set_prio(i, 8'hA0);
        set_prio(10, 8'h80); set_prio(20, 8'h40);
        pend = '0; pend[10] = 1'b1; pend[20] = 1'b1; en = '1;
        bus(1, 8'h04, 32'hFF, dummy);
        wait_cyc(3);
        bus(0, 8'h0C, 0, rd);
        check("R6 ack id", rd, 32'd20);
        check("R6 ack pulse", {31'b0, s_ack}, 1);
        check("R6 ack pulse id", {22'b0, s_ack_id}, 32'd20);
        check("R6 run_prio after ack", {24'b0, run_prio}, 32'h40);
        @(negedge clk);
        check("R6 ack pulse lasts one cycle", {31'b0, ack_pulse}, 0);
        wait_cyc(2);
        check("R5 irq low at equal running level", {31'b0, irq_out}, 0);
        bus(0, 8'h0C, 0, rd);
        check("R7 spurious id", rd, 32'd1023);
        check("R7 no pulse", {31'b0, s_ack}, 0);
        check("R7 run_prio kept", {24'b0, run_prio}, 32'h40);
        set_prio(10, 8'h20);
        wait_cyc(3);
        check("R9 irq for higher level", {31'b0, irq_out}, 1);
        bus(0, 8'h0C, 0, rd);
        check("R9 nested ack id", rd, 32'd10);
        check("R9 nested run_prio", {24'b0, run_prio}, 32'h20);
        bus(1, 8'h10, 32'd20, dummy);
        check("R8 wrong id no pulse", {31'b0, s_eoi}, 0);
        check("R8 wrong id run_prio kept", {24'b0, run_prio}, 32'h20);
        bus(1, 8'h10, 32'd10, dummy);
        check("R8 eoi pulse", {31'b0, s_eoi}, 1);
        check("R8 eoi pulse id", {22'b0, s_eoi_id}, 32'd10);
        check("R9 run_prio back to outer", {24'b0, run_prio}, 32'h40);
        bus(0, 8'h14, 0, rd);
        check("R9 running priority word", rd, 32'h40);
        bus(1, 8'h10, 32'd20, dummy);
        check("R9 run_prio idle", {24'b0, run_prio}, 32'hFF);
        bus(1, 8'h10, 32'd20, dummy);
        check("R8 eoi when idle ignored", {31'b0, s_eoi}, 0);

        // R11: drain loop with control disabled
        bus(1, 8'h00, 32'h0, dummy);
        for (int i = 0; i < N; i++) set_prio(i, 8'hA0);
        set_prio(10, 8'h80); set_prio(20, 8'h40); set_prio(30, 8'h60);
        pend = '0; pend[10] = 1'b1; pend[20] = 1'b1; pend[30] = 1'b1;
        wait_cyc(2);
        iters = 0;
        for (int k = 0; k < 8; k++) begin
            bus(0, 8'h0C, 0, rd);
            if (rd[9:0] == 10'd1023) break;
            if (iters < 3) order[iters] = rd[9:0];
            iters++;
            pend[rd[5:0]] = 1'b0;
            bus(1, 8'h10, rd, dummy);
        end
        check("R11 iterations", iters, 3);
        check("R11 first", {22'b0, order[0]}, 32'd20);
        check("R11 second", {22'b0, order[1]}, 32'd30);
        check("R11 third", {22'b0, order[2]}, 32'd10);
        check("R11 run_prio idle", {24'b0, run_prio}, 32'hFF);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule